// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block makes sure an asynchronous DRAM gets its power-up initialization and its periodic refresh. After reset it keeps the memory idle for a fixed settling pause. It then runs a short burst of refresh cycles and only after that tells the host that ordinary accesses may begin. From then on it owes one CAS-before-RAS refresh every fixed interval. The interval is chosen so that every row is refreshed within the retention period.

The block does not own the memory bus. Whenever a refresh is owed it raises a request to the access sequencer. It drives the row strobes, column strobes and write enable only in cycles where it holds the grant, and it marks those cycles with an output-enable flag so the host can switch the strobe multiplexer. If the grant is late, the missed intervals are counted. Once the grant arrives, the owed refreshes are issued back to back. All timing values are parameters counted in clock cycles. The defaults assume a 100 MHz clock: a 20000-cycle pause, 8 initial refreshes, a 1560-cycle interval and a 9-cycle refresh window.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held and after it is released, all strobes are high (inactive), we_n is high, and bus_req, strobe_oe and mem_ready are low. bus_req first goes high exactly PAUSE_CYC (20000) rising clock edges after reset is released.
- R2: After the pause, exactly INIT_REFRESHES (8) refresh cycles are issued before mem_ready rises. With the grant held high, mem_ready rises exactly 2 + 8*9 = 74 edges after bus_req first rises, with strobe_oe already low. Once high, mem_ready stays high until reset.
- R3: In every refresh cycle, the CAS lines go low at least CSR_CYC (1) cycle before the RAS lines fall. They stay low for exactly CHR_CYC (1) cycle after RAS falls, and then rise while RAS is still low.
- R4: we_n is high during every refresh cycle, including the cycles around each RAS falling edge.
- R5: Each RAS low phase lasts exactly RAS_CYC (5) cycles. RAS then stays high for at least RP_CYC (3) cycles before CAS falls again, and for at least RP_CYC + CSR_CYC cycles before RAS falls again, which gives a 9-cycle refresh window.
- R6: All NUM_RAS row strobes change together, and all NUM_CAS column strobes change together.
- R7: No strobe goes low unless bus_gnt is high. While a refresh is owed and the grant is withheld, bus_req stays high, strobe_oe stays low and no RAS edge appears.
- R8: After mem_ready rises, one refresh is owed every INTERVAL_CYC (1560) cycles, and the first becomes visible on bus_req exactly 1560 edges after mem_ready rises. Refreshes missed while the grant is withheld accumulate, up to MAX_DEBT. They are issued back to back once granted, so that with N owed, bus_req drops 1 + 9*N edges after the grant is raised. No owed refresh is ever lost.
- R9: With the grant held high, a single periodic refresh holds bus_req high for exactly 10 edges (one edge to start, then the 9-cycle window), after which bus_req falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all timing parameters count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_gnt | input | 1 | Grant from the access sequencer |
| bus_req | output | 1 | Refresh owed or refresh cycle in progress |
| strobe_oe | output | 1 | High while this block drives the strobes |
| ras_n | output | NUM_RAS | Row strobes, active low, all driven alike |
| cas_n | output | NUM_CAS | Column strobes, active low, all driven alike |
| we_n | output | 1 | Write enable, held high (read sense) for refresh |
| mem_ready | output | 1 | Initialization complete; normal accesses allowed |

## Verification
The embedded properties assume the access sequencer never withdraws bus_gnt while strobe_oe is high. They also assume the grant is never withheld long enough for MAX_DEBT intervals to pile up, because the debt counter treats an overflow as a lost refresh. The bench follows both rules in every scenario. Whenever it sees strobe_oe high it forces the grant high. In the randomized contention phase, each stall lasts at most about two refresh intervals, far below the 16-interval debt limit, while the grant otherwise toggles at random between refresh cycles.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

   typedef enum logic [1:0] {
      PH_PAUSE,
      PH_BURST,
      PH_RUN
   } init_phase_t;

   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_SETUP,
      SEQ_RASLO,
      SEQ_PRECH
   } seq_state_t;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

   function automatic int unsigned bits_for(input int unsigned v);
      return (v > 1) ? $clog2(v) : 1;
   endfunction

endpackage

// File: rtl/rfsh_cycle_timer.sv
module rfsh_cycle_timer
   import rfsh_pkg::*;
#(
   parameter int unsigned LIMIT       = 1560,
   parameter bit          AUTO_RELOAD = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic expire
);
   localparam int unsigned W = bits_for(LIMIT);
   localparam logic [W-1:0] LAST = W'(LIMIT - 1);

   logic [W-1:0] cnt;

   assign expire = en && (cnt == LAST);

   generate
      if (AUTO_RELOAD) begin : g_periodic
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cnt <= '0;
            else if (!en)    cnt <= '0;
            else if (expire) cnt <= '0;
            else             cnt <= cnt + 1'b1;
         end
      end else begin : g_oneshot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  cnt <= '0;
            else if (en && cnt != LAST)  cnt <= cnt + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/rfsh_debt_counter.sv
module rfsh_debt_counter
   import rfsh_pkg::*;
#(
   parameter int unsigned MAX_DEBT  = 16,
   parameter int unsigned INIT_LOAD = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic inc,
   input  logic dec,
   output logic nonzero
);
   localparam int unsigned CW = bits_for(MAX_DEBT + 1);
   localparam logic [CW-1:0] FULL = CW'(MAX_DEBT);

   logic [CW-1:0] count;
   logic          grow;

   assign grow    = inc && (count != FULL);
   assign nonzero = (count != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (load) begin
         count <= CW'(INIT_LOAD);
      end else begin
         unique case ({grow, dec})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R8: a refresh is only taken when one is owed
   assert_debt_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> nonzero);

   // R8: an owed refresh is never dropped at the ceiling
   assert_debt_no_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !dec && !load) |-> (count != FULL));

endmodule

// File: rtl/rfsh_cbr_seq.sv
module rfsh_cbr_seq
   import rfsh_pkg::*;
#(
   parameter int unsigned CSR_CYC = 1,
   parameter int unsigned CHR_CYC = 1,
   parameter int unsigned RAS_CYC = 5,
   parameter int unsigned RP_CYC  = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic take,
   output logic busy,
   output logic ras_on,
   output logic cas_on
);
   localparam int unsigned LONGEST = max3(CSR_CYC, RAS_CYC, RP_CYC);
   localparam int unsigned PW      = bits_for(LONGEST + 1);
   localparam int unsigned HW      = bits_for(RP_CYC + CSR_CYC + 2) + 1;

   seq_state_t     st, st_nx;
   logic [PW-1:0]  pcnt;
   logic [PW-1:0]  plen_m1;
   logic           last;

   always_comb begin
      unique case (st)
         SEQ_SETUP: plen_m1 = PW'(CSR_CYC - 1);
         SEQ_RASLO: plen_m1 = PW'(RAS_CYC - 1);
         SEQ_PRECH: plen_m1 = PW'(RP_CYC - 1);
         default:   plen_m1 = '0;
      endcase
   end

   assign last = (pcnt == plen_m1);

   always_comb begin
      st_nx = st;
      take  = 1'b0;
      unique case (st)
         SEQ_IDLE: begin
            if (go) begin
               st_nx = SEQ_SETUP;
               take  = 1'b1;
            end
         end
         SEQ_SETUP: if (last) st_nx = SEQ_RASLO;
         SEQ_RASLO: if (last) st_nx = SEQ_PRECH;
         SEQ_PRECH: begin
            if (last) begin
               if (go) begin
                  st_nx = SEQ_SETUP;
                  take  = 1'b1;
               end else begin
                  st_nx = SEQ_IDLE;
               end
            end
         end
         default: st_nx = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= SEQ_IDLE;
         pcnt <= '0;
      end else begin
         st <= st_nx;
         if (st_nx != st || st == SEQ_IDLE) pcnt <= '0;
         else                              pcnt <= pcnt + 1'b1;
      end
   end

   assign busy   = (st != SEQ_IDLE);
   assign ras_on = (st == SEQ_RASLO);
   assign cas_on = (st == SEQ_SETUP) || ((st == SEQ_RASLO) && (pcnt < PW'(CHR_CYC)));

   // Checker counters: cycles spent with RAS low / high so far
   logic [PW:0]   chk_lo;
   logic [HW-1:0] chk_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_lo <= '0;
         chk_hi <= '1;
      end else begin
         chk_lo <= ras_on ? chk_lo + 1'b1 : '0;
         if (ras_on)            chk_hi <= '0;
         else if (chk_hi != '1) chk_hi <= chk_hi + 1'b1;
      end
   end

   // R3: CAS already low in the cycle before RAS falls and while it falls
   assert_cas_leads_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_on) |-> (cas_on && $past(cas_on)));

   // R3: CAS released only after its hold time below a low RAS
   assert_cas_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_on) |-> (ras_on && chk_lo >= (PW+1)'(CHR_CYC)));

   // R5: RAS low phase has exactly its programmed width
   assert_ras_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_on) |-> (chk_lo == (PW+1)'(RAS_CYC)));

   // R5: RAS precharge respected before the next low phase
   assert_ras_precharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_on) |-> (chk_hi >= HW'(RP_CYC)));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
   import rfsh_pkg::*;
#(
   parameter int unsigned PAUSE_CYC      = 20000,
   parameter int unsigned INIT_REFRESHES = 8,
   parameter int unsigned INTERVAL_CYC   = 1560,
   parameter int unsigned CSR_CYC        = 1,
   parameter int unsigned CHR_CYC        = 1,
   parameter int unsigned RAS_CYC        = 5,
   parameter int unsigned RP_CYC         = 3,
   parameter int unsigned RC_MIN_CYC     = 9,
   parameter int unsigned MAX_DEBT       = 16,
   parameter int unsigned NUM_RAS        = 2,
   parameter int unsigned NUM_CAS        = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_gnt,
   output logic               bus_req,
   output logic               strobe_oe,
   output logic [NUM_RAS-1:0] ras_n,
   output logic [NUM_CAS-1:0] cas_n,
   output logic               we_n,
   output logic               mem_ready
);
   localparam int unsigned WINDOW_CYC = CSR_CYC + RAS_CYC + RP_CYC;

   // Elaboration-time parameter checks
   generate
      if (CSR_CYC < 1) begin : g_bad_csr
         $error("CSR_CYC must be at least 1");
      end
      if (CHR_CYC < 1 || CHR_CYC >= RAS_CYC) begin : g_bad_chr
         $error("CHR_CYC must be at least 1 and below RAS_CYC");
      end
      if (RP_CYC < 1) begin : g_bad_rp
         $error("RP_CYC must be at least 1");
      end
      if (WINDOW_CYC < RC_MIN_CYC) begin : g_bad_rc
         $error("refresh window shorter than RC_MIN_CYC");
      end
      if (INTERVAL_CYC <= WINDOW_CYC) begin : g_bad_ival
         $error("INTERVAL_CYC must exceed the refresh window");
      end
      if (MAX_DEBT < INIT_REFRESHES || INIT_REFRESHES < 1) begin : g_bad_debt
         $error("MAX_DEBT must cover INIT_REFRESHES, which must be nonzero");
      end
      if (PAUSE_CYC < 2 || NUM_RAS < 1 || NUM_CAS < 1) begin : g_bad_misc
         $error("PAUSE_CYC, NUM_RAS and NUM_CAS out of range");
      end
   endgenerate

   init_phase_t phase;
   logic        pause_done, ival_tick;
   logic        debt_nz, take, busy, ras_on, cas_on;
   logic        go;

   rfsh_cycle_timer #(.LIMIT(PAUSE_CYC), .AUTO_RELOAD(1'b0)) u_pause (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (phase == PH_PAUSE),
      .expire (pause_done)
   );

   rfsh_cycle_timer #(.LIMIT(INTERVAL_CYC), .AUTO_RELOAD(1'b1)) u_interval (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (phase == PH_RUN),
      .expire (ival_tick)
   );

   rfsh_debt_counter #(.MAX_DEBT(MAX_DEBT), .INIT_LOAD(INIT_REFRESHES)) u_debt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (pause_done),
      .inc     (ival_tick),
      .dec     (take),
      .nonzero (debt_nz)
   );

   assign go = debt_nz && bus_gnt;

   rfsh_cbr_seq #(
      .CSR_CYC (CSR_CYC),
      .CHR_CYC (CHR_CYC),
      .RAS_CYC (RAS_CYC),
      .RP_CYC  (RP_CYC)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (go),
      .take   (take),
      .busy   (busy),
      .ras_on (ras_on),
      .cas_on (cas_on)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_PAUSE;
      end else begin
         unique case (phase)
            PH_PAUSE: if (pause_done)          phase <= PH_BURST;
            PH_BURST: if (!debt_nz && !busy)   phase <= PH_RUN;
            default:                           phase <= PH_RUN;
         endcase
      end
   end

   assign bus_req   = debt_nz || busy;
   assign strobe_oe = busy;
   assign mem_ready = (phase == PH_RUN);
   assign we_n      = 1'b1;

   generate
      for (genvar i = 0; i < NUM_RAS; i++) begin : g_ras
         assign ras_n[i] = ~ras_on;
      end
      for (genvar j = 0; j < NUM_CAS; j++) begin : g_cas
         assign cas_n[j] = ~cas_on;
      end
   endgenerate

   // R1: the bus is left alone for the whole settling pause
   assert_quiet_pause_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_PAUSE) |-> (!bus_req && !strobe_oe && !mem_ready));

   // R2: ready never drops once initialization has finished
   assert_ready_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ready |=> mem_ready);

   // R7: strobes are only owned under a grant
   assert_owned_granted_R7: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_oe |-> bus_gnt);

   // R7: ownership always comes with an outstanding request
   assert_owned_requested_R7: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_oe |-> bus_req);

endmodule

// File: tb/dram_refresh_sched_test.sv
`timescale 1ns/1ps
module dram_refresh_sched_test;
   localparam int PAUSE_CYC = 20000;
   localparam int INIT_REF  = 8;
   localparam int IVAL      = 1560;
   localparam int CSR_CYC   = 1;
   localparam int CHR_CYC   = 1;
   localparam int RAS_CYC   = 5;
   localparam int RP_CYC    = 3;
   localparam int WIN       = CSR_CYC + RAS_CYC + RP_CYC;
   localparam int NR        = 2;
   localparam int NC        = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_gnt = 1'b0;
   logic          bus_req, strobe_oe, we_n, mem_ready;
   logic [NR-1:0] ras_n;
   logic [NC-1:0] cas_n;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int falls_total = 0;
   int falls_ready = 0;
   int c_ready = 0;
   int t_last  = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dram_refresh_sched #(
      .PAUSE_CYC(PAUSE_CYC), .INIT_REFRESHES(INIT_REF), .INTERVAL_CYC(IVAL),
      .CSR_CYC(CSR_CYC), .CHR_CYC(CHR_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC),
      .RC_MIN_CYC(9), .MAX_DEBT(16), .NUM_RAS(NR), .NUM_CAS(NC)
   ) uut (
      .clk(clk), .rst_n(rst_n), .bus_gnt(bus_gnt), .bus_req(bus_req),
      .strobe_oe(strobe_oe), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .mem_ready(mem_ready)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // Strobe edge monitor (samples 2 ns after each rising edge)
   logic pr = 1'b1, pc = 1'b1;
   int   cas_lo_run = 0, ras_lo_run = 0, ras_hi_run = 1000;
   always @(posedge clk) begin
      #2;
      if (!rst_n) begin
         pr = 1'b1; pc = 1'b1;
         cas_lo_run = 0; ras_lo_run = 0; ras_hi_run = 1000;
      end else begin
         automatic logic r = ras_n[0];
         automatic logic c = cas_n[0];
         if (!r && pr) begin
            falls_total++;
            if (mem_ready) falls_ready++;
            chk(!c && cas_lo_run >= CSR_CYC, "R3", "CAS low cycles before RAS fall", cas_lo_run, CSR_CYC);
            chk(we_n === 1'b1, "R4", "we_n at RAS fall", int'(we_n), 1);
            chk(ras_hi_run >= RP_CYC + CSR_CYC, "R5", "RAS high cycles before fall", ras_hi_run, RP_CYC + CSR_CYC);
            chk(ras_n == '0 && cas_n == '0, "R6", "all strobes low together", int'({ras_n, cas_n}), 0);
            chk(bus_gnt === 1'b1, "R7", "grant while RAS low", int'(bus_gnt), 1);
         end
         if (c && !pc) begin
            chk(!r && ras_lo_run == CHR_CYC, "R3", "RAS low cycles at CAS release", ras_lo_run, CHR_CYC);
         end
         if (r && !pr) begin
            chk(c && ras_lo_run == RAS_CYC, "R5", "RAS low width", ras_lo_run, RAS_CYC);
            chk(ras_n == '1 && cas_n == '1, "R6", "all strobes high together", int'({ras_n, cas_n}), (1 << (NR + NC)) - 1);
         end
         if (!c && pc) begin
            chk(r && ras_hi_run >= RP_CYC, "R5", "RAS precharge before CAS fall", ras_hi_run, RP_CYC);
            chk(we_n === 1'b1 && cas_n == '0, "R4", "we_n high and CAS lines together at CAS fall", int'(we_n), 1);
         end
         cas_lo_run = c ? 0 : cas_lo_run + 1;
         ras_lo_run = r ? 0 : ras_lo_run + 1;
         if (!r) ras_hi_run = 0;
         else if (ras_hi_run < 1000) ras_hi_run++;
         pr = r; pc = c;
      end
   end

   task automatic t_reset();
      rst_n   = 1'b0;
      bus_gnt = 1'b1;
      repeat (5) step();
      chk(ras_n == '1 && cas_n == '1, "R1", "strobes idle in reset", int'({ras_n, cas_n}), (1 << (NR + NC)) - 1);
      chk(we_n === 1'b1, "R1", "we_n in reset", int'(we_n), 1);
      chk(!bus_req && !strobe_oe && !mem_ready, "R1", "req/oe/ready in reset",
          int'({bus_req, strobe_oe, mem_ready}), 0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_pause();
      int n = 0;
      bit early = 1'b0;
      while (!bus_req) begin
         step();
         n++;
         if (strobe_oe || mem_ready || ras_n != '1 || cas_n != '1) early = 1'b1;
      end
      chk(n == PAUSE_CYC, "R1", "edges from reset release to first request", n, PAUSE_CYC);
      chk(!early, "R1", "bus untouched during pause", int'(early), 0);
   endtask

   task automatic t_burst();
      int n = 0;
      int f0 = falls_total;
      while (!mem_ready) begin
         step();
         n++;
      end
      chk(falls_total - f0 == INIT_REF, "R2", "refreshes before ready", falls_total - f0, INIT_REF);
      chk(n == 2 + INIT_REF * WIN, "R2", "edges from request to ready", n, 2 + INIT_REF * WIN);
      chk(!strobe_oe, "R2", "strobes released at ready", int'(strobe_oe), 0);
      c_ready = cyc;
   endtask

   task automatic t_interval();
      int n = 0;
      int t1;
      while (!bus_req) begin
         step();
         n++;
      end
      chk(n == IVAL, "R8", "edges from ready to first periodic request", n, IVAL);
      t1 = cyc;
      n = 0;
      while (bus_req) begin
         step();
         n++;
      end
      chk(n == 1 + WIN, "R9", "request hold for one refresh", n, 1 + WIN);
      while (!bus_req) step();
      chk(cyc - t1 == IVAL, "R8", "spacing of periodic requests", cyc - t1, IVAL);
      t_last = cyc;
      while (bus_req) step();
      chk(mem_ready === 1'b1, "R2", "ready still high", int'(mem_ready), 1);
   endtask

   task automatic t_stall();
      int f0 = falls_total;
      int n = 0;
      bit owned = 1'b0;
      bus_gnt = 1'b0;
      while (cyc < t_last + 3 * IVAL + 50) begin
         step();
         if (strobe_oe) owned = 1'b1;
      end
      chk(falls_total == f0, "R7", "no RAS fall without grant", falls_total - f0, 0);
      chk(!owned, "R7", "no strobe ownership without grant", int'(owned), 0);
      chk(bus_req === 1'b1, "R7", "request held while owed", int'(bus_req), 1);
      bus_gnt = 1'b1;
      while (bus_req) begin
         step();
         n++;
      end
      chk(n == 1 + 3 * WIN, "R8", "back-to-back drain of three owed", n, 1 + 3 * WIN);
      chk(falls_total - f0 == 3, "R8", "owed refreshes issued", falls_total - f0, 3);
   endtask

   task automatic t_random();
      int stall = 0;
      int owed;
      for (int i = 0; i < 12 * IVAL; i++) begin
         step();
         if (strobe_oe) begin
            bus_gnt = 1'b1;
         end else if (stall > 0) begin
            bus_gnt = 1'b0;
            stall--;
         end else begin
            bus_gnt = ($urandom % 3) == 0;
            if (($urandom % 1500) == 0) stall = $urandom % 3000;
         end
      end
      bus_gnt = 1'b1;
      while (bus_req) step();
      owed = (cyc - c_ready) / IVAL;
      chk(falls_ready == owed, "R8", "refreshes since ready vs intervals elapsed", falls_ready, owed);
      chk(mem_ready === 1'b1, "R2", "ready sticky under contention", int'(mem_ready), 1);
   endtask

   initial begin
      #(190000 * 4);
      checks++;
      fails++;
      $display("FAIL watchdog R8: run did not finish, actual %0d expected %0d cycles", cyc, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      t_reset();
      t_pause();
      t_burst();
      t_interval();
      t_stall();
      t_random();
      repeat (3) step();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule